// File: doc/BRIEF.md
# Peripheral Bus Clock Divider with Update Handshake

This block derives a slower peripheral bus rate from its input clock without leaving the clock domain. A 32-bit control word holds a divide field, a ready flag and an output enable. The divided rate appears two ways: as a one-cycle enable pulse that marks the last input cycle of each output period, and as a level waveform that a later stage can treat as a divided clock. With a ratio of 1 the pulse output is simply held high.

Changing the ratio is a handshake. A divide value written while the block is ready is held pending, and ready drops. The pending value replaces the running one only at the end of the current output period, so no short or stretched period is produced. Ready then returns, and a read shows the newly applied value. All writes are blocked unless the system key-unlock input is high.

Top module: `bus_clk_div`

## Requirements
- R1: After reset the control word reads 0x0000_8800: divide field (bits 6:0) is 0, ready (bit 11) is 1 and enable (bit 15) is 1.
- R2: With divide field value D and enable set, the output period is D+1 input cycles, and `div_pulse` is high for exactly one cycle per period, in its last cycle.
- R3: While enable (bit 15) is 0, both `div_pulse` and `div_level` stay low; the period counter keeps running.
- R4: `div_level` is high, when enabled, during period positions 0 through floor(D/2) and low for the remaining positions of each period.
- R5: An accepted divide write clears ready (bit 11) from the next cycle on, and ready stays 0 until the pending value is applied.
- R6: A pending divide value is applied at the end of the output period in progress; until then bits 6:0 read the old value, and afterwards they read the new one.
- R7: While ready is 0, the divide field of a write is ignored; its enable bit is still taken.
- R8: A write while `key_unlocked` is low changes nothing: enable, divide field and ready all keep their values.
- R9: A divide field of 0 (ratio 1) gives a `div_pulse` that is high on every cycle while enabled.
- R10: Control word bits other than 6:0, 11 and 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data: bits 6:0 divide field, bit 15 enable |
| key_unlocked | input | 1 | High when the system key allows clock register writes |
| reg_rdata | output | 32 | Control word read value |
| div_pulse | output | 1 | One-cycle enable at the end of each output period |
| div_level | output | 1 | Divided waveform, high in the first half of each period |

## Verification
The bench targets a ratio write landing mid-period: a design that applied it at once would emit a short period and show the new value before the boundary, which the per-cycle scoreboard catches. A second write sent while the first is still pending must leave the divide field untouched; a design that overwrote the pending value would end on the wrong ratio. Locked writes, the gated output with a running counter, the ratio 1 constant enable and the 128 ratio extreme are each driven, so a design that lets a locked write through, counts only while enabled, or misses the largest field value gives wrong pulse counts or read values.

// File: rtl/bdiv_pkg.sv
package bdiv_pkg;
  localparam int REG_W     = 32;
  localparam int DIV_LSB   = 0;
  localparam int READY_BIT = 11;
  localparam int EN_BIT    = 15;
  localparam int MAX_W     = 16;

  // Ratio produced by a divide field value.
  function automatic logic [MAX_W:0] ratio_of(input logic [MAX_W-1:0] field);
    return {1'b0, field} + 1'b1;
  endfunction

  // Level output is high in the first half (rounded up) of the period.
  function automatic logic level_on(input logic [MAX_W-1:0] pos,
                                    input logic [MAX_W-1:0] field);
    return pos <= (field >> 1);
  endfunction
endpackage

// File: rtl/bdiv_ctrl.sv
module bdiv_ctrl #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  input  logic             unlocked,
  input  logic             period_end,
  output logic [DIV_W-1:0] cur_div,
  output logic             enable,
  output logic             ready,
  output logic             load_evt
);
  import bdiv_pkg::*;

  logic             pend_q;
  logic [DIV_W-1:0] pend_div;
  logic             en_q;
  logic             cfg_wr;
  logic             take_div;

  assign cfg_wr   = wr_en & unlocked;
  assign take_div = cfg_wr & ~pend_q;
  assign load_evt = pend_q & period_end;
  assign ready    = ~pend_q;
  assign enable   = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_div  <= '0;
      pend_div <= '0;
      pend_q   <= 1'b0;
      en_q     <= 1'b1;
    end else begin
      if (cfg_wr) en_q <= wdata[EN_BIT];
      if (take_div) begin
        pend_q   <= 1'b1;
        pend_div <= wdata[DIV_LSB +: DIV_W];
      end else if (load_evt) begin
        pend_q  <= 1'b0;
        cur_div <= pend_div;
      end
    end
  end

  // R5: accepted write drops ready on the next cycle
  a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    take_div |=> !ready);
  // R6: applied ratio changes only through a boundary load
  a_r6_load_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_div != $past(cur_div)) |-> $past(load_evt));
  // R7: busy write does not disturb the running ratio or the handshake
  a_r7_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !ready && !period_end) |=> (!ready && $stable(cur_div)));
  // R8: locked write cannot start an update
  a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && ready) |=> (ready && $stable(enable)));
endmodule

// File: rtl/bdiv_phase.sv
module bdiv_phase #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cur_div,
  input  logic             enable,
  output logic             period_end,
  output logic             div_pulse,
  output logic             div_level
);
  import bdiv_pkg::*;

  logic [DIV_W-1:0] cnt;

  assign period_end = (cnt == cur_div);
  assign div_pulse  = enable & period_end;
  assign div_level  = enable & level_on(MAX_W'(cnt), MAX_W'(cur_div));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (period_end) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R2: position never passes the period end
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cur_div);
  // R3: gated outputs stay quiet
  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!div_pulse && !div_level));
  // R9: ratio 1 holds the enable high
  a_r9_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cur_div == '0) |-> div_pulse);
  // R4: level is low in the last cycle of periods longer than one
  a_r4_level_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && cur_div != '0) |-> !div_level);
endmodule

// File: rtl/bus_clk_div.sv
module bus_clk_div #(
  parameter int DIV_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        key_unlocked,
  output logic [31:0] reg_rdata,
  output logic        div_pulse,
  output logic        div_level
);
  import bdiv_pkg::*;

  logic [DIV_W-1:0] cur_div;
  logic             enable;
  logic             ready;
  logic             load_evt;
  logic             period_end;

  bdiv_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .wdata      (reg_wdata),
    .unlocked   (key_unlocked),
    .period_end (period_end),
    .cur_div    (cur_div),
    .enable     (enable),
    .ready      (ready),
    .load_evt   (load_evt)
  );

  bdiv_phase #(.DIV_W(DIV_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_div    (cur_div),
    .enable     (enable),
    .period_end (period_end),
    .div_pulse  (div_pulse),
    .div_level  (div_level)
  );

  always_comb begin
    reg_rdata                      = '0;
    reg_rdata[DIV_LSB +: DIV_W]    = cur_div;
    reg_rdata[READY_BIT]           = ready;
    reg_rdata[EN_BIT]              = enable;
  end

  // R1: reset state of the handshake
  a_r1_ready_after_reset: assert property (@(posedge clk)
    !rst_n |=> ready);
  // R10: unused bits never set
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~32'h0000_887F) == 32'h0);
endmodule

// File: tb/tb_bus_clk_div.sv
module tb_bus_clk_div;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic        key_unlocked;
  logic [31:0] reg_rdata;
  logic        div_pulse;
  logic        div_level;

  always #4 clk = ~clk;

  bus_clk_div dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .key_unlocked(key_unlocked), .reg_rdata(reg_rdata),
    .div_pulse(div_pulse), .div_level(div_level)
  );

  typedef struct {
    logic        pulse;
    logic        level;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  // reference model: countdown of cycles left in the period
  int m_left = 1, m_ratio = 1, m_pratio = 1;
  bit m_pend = 1'b0, m_en = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      exp_t e;
      bit acc;
      int pos;
      acc = reg_wr && key_unlocked && !m_pend;
      if (m_left == 1) begin
        if (m_pend) begin m_ratio = m_pratio; m_pend = 1'b0; end
        m_left = m_ratio;
      end else begin
        m_left = m_left - 1;
      end
      if (reg_wr && key_unlocked) m_en = reg_wdata[15];
      if (acc) begin m_pend = 1'b1; m_pratio = int'(reg_wdata[6:0]) + 1; end
      pos     = m_ratio - m_left;
      e.pulse = m_en && (m_left == 1);
      e.level = m_en && (2 * pos < m_ratio);
      e.rd    = {16'h0, m_en, 3'b0, !m_pend, 4'b0, 7'(m_ratio - 1)};
      e.tag   = cur_tag;
      sb_q.push_back(e);
    end
  end

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, {31'b0, div_pulse}, {31'b0, e.pulse}, "pulse");
      chk(e.tag, {31'b0, div_level}, {31'b0, e.level}, "level");
      chk(e.tag, reg_rdata, e.rd, "rdata");
    end
  end

  task automatic do_write(input logic [31:0] d, input bit unl);
    reg_wr = 1'b1; reg_wdata = d; key_unlocked = unl;
    @(negedge clk);
    reg_wr = 1'b0; key_unlocked = 1'b1;
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (reg_rdata[11] !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    chk(tag, {31'b0, reg_rdata[11]}, 32'h1, "ready returns");
  endtask

  task automatic count_pulses(input int cyc, output int np, output int nl);
    np = 0; nl = 0;
    for (int i = 0; i < cyc; i++) begin
      if (div_pulse) np++;
      if (div_level) nl++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int lim = 0;
    while (lim < 100000) begin @(posedge clk); lim++; end
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int np, nl;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; key_unlocked = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", reg_rdata, 32'h0000_8800, "reset word");
    chk("R10", {16'h0, reg_rdata[31:16]}, 32'h0, "upper bits zero");
    rst_n = 1'b1;

    // R9: ratio 1 constant enable
    cur_tag = "R9";
    count_pulses(10, np, nl);
    chk("R9", np, 10, "ratio 1 pulses");

    // R5, R6: ratio 4 write
    cur_tag = "R6";
    do_write(32'h0000_8003, 1'b1);
    chk("R5", {31'b0, reg_rdata[11]}, 32'h0, "ready low after write");
    wait_ready("R5");
    chk("R6", {25'b0, reg_rdata[6:0]}, 32'd3, "applied value");
    cur_tag = "R2";
    count_pulses(32, np, nl);
    chk("R2", np, 8, "ratio 4 pulses");
    chk("R4", nl, 16, "ratio 4 level cycles");

    // R6 mid-period write, R7 second write while pending
    cur_tag = "R7";
    @(negedge clk);
    do_write(32'h0000_8007, 1'b1);
    chk("R6", {25'b0, reg_rdata[6:0]}, 32'd3, "old value while pending");
    do_write(32'h0000_8001, 1'b1);
    wait_ready("R7");
    chk("R7", {25'b0, reg_rdata[6:0]}, 32'd7, "busy write ignored");
    count_pulses(64, np, nl);
    chk("R2", np, 8, "ratio 8 pulses");
    chk("R4", nl, 32, "ratio 8 level cycles");

    // R8: locked write
    cur_tag = "R8";
    do_write(32'h0000_0002, 1'b0);
    chk("R8", reg_rdata, 32'h0000_8807, "locked write ignored");
    count_pulses(16, np, nl);
    chk("R8", np, 2, "pulses unchanged after locked write");

    // R3: gate off, keep ratio
    cur_tag = "R3";
    do_write(32'h0000_0007, 1'b1);
    wait_ready("R3");
    count_pulses(40, np, nl);
    chk("R3", np, 0, "gated pulses");
    chk("R3", nl, 0, "gated level");
    do_write(32'h0000_8007, 1'b1);
    wait_ready("R3");
    count_pulses(16, np, nl);
    chk("R3", np, 2, "pulses after re-enable");

    // R2 at maximum ratio 128
    cur_tag = "R2";
    do_write(32'h0000_807F, 1'b1);
    wait_ready("R2");
    chk("R6", {25'b0, reg_rdata[6:0]}, 32'd127, "max field readback");
    count_pulses(384, np, nl);
    chk("R2", np, 3, "ratio 128 pulses");
    chk("R4", nl, 192, "ratio 128 level cycles");

    // back to ratio 1
    cur_tag = "R9";
    do_write(32'h0000_8000, 1'b1);
    wait_ready("R9");
    count_pulses(12, np, nl);
    chk("R9", np, 12, "ratio 1 after change");
    chk("R10", reg_rdata, 32'h0000_8800, "final word");
    finish_run();
  end
endmodule